// File: doc/BRIEF.md
# Dual-Channel Comparator Register Interface

This block is the control and status register bank for a pair of analog comparator channels. It gives each channel a 32-bit control word and adds one 32-bit status word that both channels share. A single-cycle, word-addressed bus reads and writes all three words. Every word also has three alias addresses that clear, set or invert the bits selected by the write data, so software can change individual fields in one write without a read-modify-write.

The configuration fields of each channel are driven straight out to the comparator datapath. These fields are enable, pin output enable, output inversion, event polarity, positive input select and negative input select. The sampled comparator results come back in and are shown as read-only bits. A freeze control is writable only while the CPU is in debug mode and takes effect on the next entry into debug. While freeze is in force, the sampled results are held.

The bus address is a word index. Bits [1:0] pick the access kind: 0 is a plain write, 1 clears, 2 sets and 3 inverts. The upper bits pick the word: 0 is channel 1, 1 is channel 2 and 2 is the status word. As byte offsets these are 0x00, 0x10 and 0x20, with the aliases at +0x4, +0x8 and +0xC.

Top module: `cmp_regbank`

## Requirements
- R1: After reset, each control word reads 0x0000_00C3. In that word, event polarity (bits 7:6) is 2'b11, negative select (bits 1:0) is 2'b11 and every other field is 0. The status word reads 0, all enables are low and freeze_active is low.
- R2: A plain write (kind 0) to a control word stores only its writable bits, given by mask 0x0000_E0D3. These are bit 15 enable, bit 14 pin output enable, bit 13 inversion, bits 7:6 event polarity, bit 4 positive select and bits 1:0 negative select. Every bit outside those fields and bit 8 reads 0.
- R3: A write to the clear alias (kind 1) clears each writable bit whose write-data bit is 1 and leaves all other bits unchanged.
- R4: A write to the set alias (kind 2) sets each writable bit whose write-data bit is 1 and leaves all other bits unchanged.
- R5: A write to the invert alias (kind 3) toggles each writable bit whose write-data bit is 1 and leaves all other bits unchanged.
- R6: A read of any alias address returns 0 and changes no register.
- R7: The channel result inputs are registered once. Each result then reads back in bit 8 of its own control word and in status bit 0 (channel 1) or bit 1 (channel 2). Writes through the plain address or any alias never change these bits.
- R8: Status bit 14 (freeze) can be written only while dbg_mode is high. Outside debug it reads 0, and writes to it are ignored.
- R9: A freeze value written during debug takes effect only at the next rising edge of dbg_mode. While in debug, reads return the value latched at entry, and freeze_active equals dbg_mode AND that latched value.
- R10: While freeze_active is high, the registered result bits hold their value.
- R11: Clearing the enable bit leaves every other control field unchanged.
- R12: Status bit 13 (stop in idle) can be written at any time and is driven on idle_stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | AW (4) | Word address: [AW-1:2] selects the word, [1:0] the access kind |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| dbg_mode | input | 1 | CPU is in debug exception mode |
| cmp_result | input | NCH | Comparator results from the datapath |
| ch_enable | output | NCH | Per-channel enable |
| ch_pin_oe | output | NCH | Per-channel result-to-pin enable |
| ch_invert | output | NCH | Per-channel output inversion |
| ch_evt_sel | output | 2*NCH | Per-channel event polarity select, 2 bits each |
| ch_pos_sel | output | NCH | Per-channel positive input select |
| ch_neg_sel | output | 2*NCH | Per-channel negative input select, 2 bits each |
| idle_stop | output | 1 | Stop-in-idle control |
| freeze_active | output | 1 | Freeze currently in force |

## Verification
The assertions assume that cmp_result and dbg_mode are already synchronous to clk and change only between edges. They also assume that a read is valid in the same cycle in which its address is presented. The bench keeps to this by driving every input on the falling edge and sampling bus_rdata one nanosecond later. It moves dbg_mode only on falling edges, so that entry and exit each show up in a single known cycle.

// File: rtl/cmp_regbank.sv
module cmp_regbank #(
  parameter int NCH = 2,
  localparam int AW = $clog2((NCH + 1) * 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              dbg_mode,
  input  logic [NCH-1:0]    cmp_result,
  output logic [NCH-1:0]    ch_enable,
  output logic [NCH-1:0]    ch_pin_oe,
  output logic [NCH-1:0]    ch_invert,
  output logic [2*NCH-1:0]  ch_evt_sel,
  output logic [NCH-1:0]    ch_pos_sel,
  output logic [2*NCH-1:0]  ch_neg_sel,
  output logic              idle_stop,
  output logic              freeze_active
);
  localparam int SW = AW - 2;
  localparam logic [31:0] CTRL_WMASK = 32'h0000_E0D3;
  localparam logic [31:0] CTRL_RST   = 32'h0000_00C3;

  function automatic logic [31:0] apply(input logic [31:0] old, input logic [31:0] wd,
                                        input logic [1:0] k, input logic [31:0] m);
    logic [31:0] nv;
    case (k)
      2'd0:    nv = wd;
      2'd1:    nv = old & ~wd;
      2'd2:    nv = old | wd;
      default: nv = old ^ wd;
    endcase
    return (old & ~m) | (nv & m);
  endfunction

  wire [1:0]    kind = bus_addr[1:0];
  wire [SW-1:0] sel  = bus_addr[AW-1:2];

  logic [31:0]    ctrl_q [NCH];
  logic [NCH-1:0] res_q;
  logic idle_q, frz_wr, frz_act, dbg_q;

  wire dbg_entry = dbg_mode & ~dbg_q;
  wire frz_view  = dbg_entry ? frz_wr : frz_act;
  assign freeze_active = dbg_mode & frz_view;
  assign idle_stop     = idle_q;

  wire        st_wr   = bus_we && (sel == SW'(NCH));
  wire [31:0] st_cur  = {17'b0, frz_wr, idle_q, 13'b0};
  wire [31:0] st_mask = dbg_mode ? 32'h0000_6000 : 32'h0000_2000;
  wire [31:0] st_next = apply(st_cur, bus_wdata, kind, st_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) ctrl_q[i] <= CTRL_RST;
    end else begin
      for (int i = 0; i < NCH; i++)
        if (bus_we && sel == SW'(i))
          ctrl_q[i] <= apply(ctrl_q[i], bus_wdata, kind, CTRL_WMASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= 1'b0;
      frz_wr  <= 1'b0;
      frz_act <= 1'b0;
      dbg_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      dbg_q <= dbg_mode;
      if (st_wr) begin
        idle_q <= st_next[13];
        frz_wr <= st_next[14];
      end
      if (dbg_entry) frz_act <= frz_wr;
      if (!freeze_active) res_q <= cmp_result;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign ch_enable[g]          = ctrl_q[g][15];
    assign ch_pin_oe[g]          = ctrl_q[g][14];
    assign ch_invert[g]          = ctrl_q[g][13];
    assign ch_evt_sel[2*g +: 2]  = ctrl_q[g][7:6];
    assign ch_pos_sel[g]         = ctrl_q[g][4];
    assign ch_neg_sel[2*g +: 2]  = ctrl_q[g][1:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (kind == 2'd0) begin
      for (int i = 0; i < NCH; i++)
        if (sel == SW'(i)) bus_rdata = ctrl_q[i] | (32'(res_q[i]) << 8);
      if (sel == SW'(NCH)) begin
        bus_rdata[14]      = dbg_mode & frz_view;
        bus_rdata[13]      = idle_q;
        bus_rdata[NCH-1:0] = res_q;
      end
    end
  end

  AST_CTRL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 2'd0 && sel < SW'(NCH)) |-> ((bus_rdata & ~32'h0000_E1D3) == 32'h0)); // R2
  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != 2'd0) |-> (bus_rdata == 32'h0)); // R6
  AST_FRZ_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_mode && kind == 2'd0 && sel == SW'(NCH)) |-> !bus_rdata[14]); // R8
  AST_FRZ_WR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_mode |=> $stable(frz_wr)); // R8
  AST_FRZ_STEADY_IN_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && dbg_q) |=> (!dbg_mode || $stable(freeze_active))); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_active |=> $stable(res_q)); // R10
endmodule

// File: tb/cmp_regbank_tb.sv
`timescale 1ns/1ps
module cmp_regbank_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_mode = 1'b0;
  logic [1:0]  cmp_result = '0;
  logic [1:0]  ch_enable, ch_pin_oe, ch_invert, ch_pos_sel;
  logic [3:0]  ch_evt_sel, ch_neg_sel;
  logic        idle_stop, freeze_active;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmp_regbank #(.NCH(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_mode(dbg_mode),
    .cmp_result(cmp_result), .ch_enable(ch_enable), .ch_pin_oe(ch_pin_oe),
    .ch_invert(ch_invert), .ch_evt_sel(ch_evt_sel), .ch_pos_sel(ch_pos_sel),
    .ch_neg_sel(ch_neg_sel), .idle_stop(idle_stop), .freeze_active(freeze_active));

  // {req, write addr, write data, check addr, expected}
  localparam int NV = 11;
  localparam logic [87:0] VEC [NV] = '{
    {8'd2,  8'd0,  32'hFFFF_FFFF, 8'd0, 32'h0000_E0D3},  // R2 plain write, reserved dropped
    {8'd3,  8'd1,  32'h0000_4041, 8'd0, 32'h0000_A092},  // R3 clear alias
    {8'd4,  8'd2,  32'h0000_0050, 8'd0, 32'h0000_A0D2},  // R4 set alias
    {8'd5,  8'd3,  32'h0000_E0D3, 8'd0, 32'h0000_4001},  // R5 invert alias
    {8'd2,  8'd4,  32'h1234_A0C2, 8'd4, 32'h0000_A0C2},  // R2 second channel
    {8'd7,  8'd0,  32'h0000_0100, 8'd0, 32'h0000_0000},  // R7 result bit not writable
    {8'd4,  8'd6,  32'hFFFF_FFFF, 8'd4, 32'h0000_E0D3},  // R4 set alias ch2
    {8'd7,  8'd7,  32'h0000_0100, 8'd4, 32'h0000_E0D3},  // R7 invert ignores result bit
    {8'd12, 8'd10, 32'hFFFF_FFFF, 8'd8, 32'h0000_2000},  // R12 stop-idle set, freeze locked
    {8'd8,  8'd11, 32'h0000_6003, 8'd8, 32'h0000_0000},  // R8 invert outside debug
    {8'd12, 8'd8,  32'h0000_2000, 8'd8, 32'h0000_2000}   // R12 plain write
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'd0, r); check("R1", r, 32'h0000_00C3);
    rd(4'd4, r); check("R1", r, 32'h0000_00C3);
    rd(4'd8, r); check("R1", r, 32'h0);
    check("R1", {24'b0, ch_enable, ch_evt_sel, ch_neg_sel[1:0]}, {24'b0, 2'b00, 4'hF, 2'b11});
    check("R1", {31'b0, freeze_active}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][75:72], VEC[i][71:40]);
      rd(VEC[i][35:32], r);
      check($sformatf("R%0d", VEC[i][87:80]), r, VEC[i][31:0]);
    end

    // R6 alias reads return 0, no side effect
    wr(4'd0, 32'h0000_A0C1);
    rd(4'd1, r); check("R6", r, 32'h0);
    rd(4'd2, r); check("R6", r, 32'h0);
    rd(4'd3, r); check("R6", r, 32'h0);
    @(negedge clk);
    rd(4'd0, r); check("R6", r, 32'h0000_A0C1);
    wr(4'd0, 32'h0);

    // R7 result sampling
    @(negedge clk); cmp_result = 2'b10;
    @(negedge clk);
    rd(4'd4, r); check("R7", r, 32'h0000_E1D3);
    rd(4'd0, r); check("R7", r, 32'h0);
    rd(4'd8, r); check("R7", r, 32'h0000_2002);

    // R11 clearing enable keeps other fields
    wr(4'd5, 32'h0000_8000);
    rd(4'd4, r); check("R11", r, 32'h0000_61D3);
    check("R11", {26'b0, ch_enable, ch_pin_oe, ch_evt_sel[3:2]}, {26'b0, 2'b00, 2'b10, 2'b11});

    // R9 freeze written in debug waits for next entry
    dbg_mode = 1'b1;
    wr(4'd10, 32'h0000_4000);
    rd(4'd8, r); check("R9", r, 32'h0000_2002);
    check("R9", {31'b0, freeze_active}, 32'h0);
    @(negedge clk); dbg_mode = 1'b0;
    rd(4'd8, r); check("R8", r, 32'h0000_2002);
    @(negedge clk); dbg_mode = 1'b1;
    rd(4'd8, r); check("R9", r, 32'h0000_6002);
    check("R9", {31'b0, freeze_active}, 32'h1);
    @(negedge clk);
    rd(4'd8, r); check("R9", r, 32'h0000_6002);

    // R10 results held while frozen
    cmp_result = 2'b01;
    repeat (2) @(negedge clk);
    rd(4'd8, r); check("R10", r, 32'h0000_6002);
    dbg_mode = 1'b0;
    repeat (2) @(negedge clk);
    rd(4'd8, r); check("R10", r, 32'h0000_2001);

    // R8 write outside debug cannot touch freeze; R12 idle cleared
    wr(4'd8, 32'h0000_0000);
    rd(4'd8, r); check("R12", r, 32'h0000_0001);
    check("R12", {31'b0, idle_stop}, 32'h0);
    dbg_mode = 1'b1;
    rd(4'd8, r); check("R8", r, 32'h0000_4001);
    @(negedge clk); dbg_mode = 1'b0;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule